// File: doc/BRIEF.md
# Node Cache Coherence Agent (MSI, directory protocol)

This block is the cache controller that sits in one processing node of a machine whose coherence is kept by a home directory. Unlike a snooping design, it never watches a shared bus. Every miss and every ownership change is negotiated through explicit point-to-point messages with the home.

The agent holds a small direct-mapped cache. Each line carries a tag, a 32-bit data word and a coherence state: invalid, shared or modified. The processor side uses a valid/ready handshake. A request that hits completes in the same cycle. A request that misses stalls until the home has answered, and only one miss may be outstanding at a time.

Outgoing requests leave on a request channel:
- read for sharing;
- read for ownership;
- writeback of a dirty victim.

Messages from the home arrive on a single inbound channel:
- shared-data reply;
- exclusive-data reply;
- invalidate;
- data fetch;
- negative acknowledge.

The agent answers invalidates and fetches on a separate response channel. After a negative acknowledge it waits a fixed back-off and then sends the same request again.

Top module: `coh_node_agent`

## Requirements
- R1: A load whose line is present in shared or modified state with a matching tag raises `cpu_ready` in the same cycle that `cpu_valid` is seen, with `cpu_rdata` holding the line data and no request message.
- R2: A load that misses puts a read-for-sharing request (`req_type` 0, `req_addr` = load address) on the request channel one cycle after the miss is seen. After a shared-data reply (`in_type` 0) to that address, the line holds the reply data in shared state and the load completes in the following cycle.
- R3: A store that misses, or finds its line only shared, sends a read-for-ownership request (`req_type` 1). After an exclusive-data reply (`in_type` 1), the store completes in the following cycle and leaves the line modified with the store data.
- R4: A store to a modified line with a matching tag completes in the same cycle, updates the data and sends no message.
- R5: An invalidate (`in_type` 2) for a present line makes the line invalid and produces an acknowledge (`rsp_type` 0, `rsp_addr` = invalidate address) in the next cycle.
- R6: An invalidate for a line that is not present is still acknowledged one cycle later, and it leaves the cache contents unchanged: a later access to the resident line still hits.
- R7: A fetch (`in_type` 3) for a modified line returns the line data (`rsp_type` 1) one cycle later and downgrades the line to shared, so that a following store needs a new ownership request. A fetch for a line that is not present returns data 0.
- R8: A miss whose victim line is modified under another tag first sends a writeback (`req_type` 2) carrying the victim address and data. The read request follows in the next cycle.
- R9: A negative acknowledge (`in_type` 4) to the outstanding address causes exactly `NACK_WAIT` (4) quiet cycles, after which the identical request reappears five cycles after the negative acknowledge was received.
- R10: An invalidate that arrives for the same line while a miss to that line is outstanding is acknowledged at once. The miss then completes normally when its reply arrives.
- R11: While a miss is outstanding, `cpu_ready` stays low and no second read request is issued before a reply or negative acknowledge.
- R12: After reset, no message is driven, `cpu_ready` is low, and every line is invalid, so the first access to any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| req_valid | output | 1 | Request message to home valid |
| req_type | output | 2 | 0 read shared, 1 read exclusive, 2 writeback |
| req_addr | output | ADDR_W | Address of the request message |
| req_data | output | DATA_W | Writeback data |
| in_valid | input | 1 | Message from home valid |
| in_type | input | 3 | 0 shared reply, 1 exclusive reply, 2 invalidate, 3 fetch, 4 negative acknowledge |
| in_addr | input | ADDR_W | Address of the inbound message |
| in_data | input | DATA_W | Reply data |
| rsp_valid | output | 1 | Response to home valid |
| rsp_type | output | 1 | 0 invalidate acknowledge, 1 fetch data |
| rsp_addr | output | ADDR_W | Address being answered |
| rsp_data | output | DATA_W | Line data for a fetch |

## Verification
Each result has a fixed due cycle:
- A hit answers in the cycle of the request.
- A clean miss shows its request one cycle later, takes the reply in the cycle after that, and completes three cycles after it began.
- An eviction adds one cycle, and each negative acknowledge adds six.
- Invalidate and fetch responses appear exactly one cycle after the inbound message.

The bench counts cycles from the first cycle of every request, drives inputs and samples outputs one nanosecond after the rising edge, and compares each completion cycle, message position and response against these figures from its own model of the lines and the home memory.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_M = 2'd2} line_st_e;
  typedef enum logic [1:0] {OQ_RD = 2'd0, OQ_RDX = 2'd1, OQ_WB = 2'd2} oreq_e;
  typedef enum logic [2:0] {
    IM_RDREP = 3'd0, IM_EXREP = 3'd1, IM_INV = 3'd2, IM_FETCH = 3'd3, IM_NACK = 3'd4
  } inmsg_e;
  typedef enum logic {RS_INVACK = 1'b0, RS_DATA = 1'b1} rsp_e;
endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [TAG_W-1:0]  a_tag,
  output line_st_e          a_st,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [TAG_W-1:0]  b_tag,
  output line_st_e          b_st,
  output logic [DATA_W-1:0] b_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  line_st_e          fill_st,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic              chg_en,
  input  logic [IDX_W-1:0]  chg_idx,
  input  line_st_e          chg_st
);
  logic [TAG_W-1:0]  tag_v  [LINES];
  line_st_e          st_v   [LINES];
  logic [DATA_W-1:0] data_v [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_q, st_d;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q, data_d;
    logic              sel_fill, sel_wr, data_ce;

    assign sel_fill = fill_en && (fill_idx == IDX_W'(g));
    assign sel_wr   = wr_en && (wr_idx == IDX_W'(g));
    assign data_ce  = sel_fill || sel_wr;

    always_comb begin
      st_d   = st_q;
      data_d = data_q;
      if (sel_fill) begin
        st_d   = fill_st;
        data_d = fill_data;
      end
      if (sel_wr) data_d = wr_data;
      if (chg_en && (chg_idx == IDX_W'(g))) st_d = chg_st;
      if (inv_en && (inv_idx == IDX_W'(g))) st_d = LS_I;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LS_I;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (sel_fill) tag_q <= fill_tag;
      if (data_ce)  data_q <= data_d;
    end

    assign tag_v[g]  = tag_q;
    assign st_v[g]   = st_q;
    assign data_v[g] = data_q;

    // R2/R3: a fill leaves the line in the state the reply called for
    p_fill_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fill |=> (st_q == $past(fill_st)) && (data_q == $past(fill_data)));
    // R4: a processor store keeps the line modified and holds the new word
    p_store_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (st_q == LS_M) && (data_q == $past(wr_data)));
  end

  assign a_tag  = tag_v[a_idx];
  assign a_st   = st_v[a_idx];
  assign a_data = data_v[a_idx];
  assign b_tag  = tag_v[b_idx];
  assign b_st   = st_v[b_idx];
  assign b_data = data_v[b_idx];
endmodule

// File: rtl/coh_probe_unit.sv
module coh_probe_unit
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  output logic [IDX_W-1:0]  b_idx,
  input  logic [TAG_W-1:0]  b_tag,
  input  line_st_e          b_st,
  input  logic [DATA_W-1:0] b_data,
  output logic              busy,
  output logic              chg_en,
  output line_st_e          chg_st,
  output logic              rsp_valid,
  output logic              rsp_type,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  logic is_inv, is_fetch, present;
  logic              rv_d, rt_d;
  logic [DATA_W-1:0] rdat_d;

  assign b_idx    = in_addr[IDX_W-1:0];
  assign is_inv   = in_valid && (in_type == IM_INV);
  assign is_fetch = in_valid && (in_type == IM_FETCH);
  assign busy     = is_inv || is_fetch;
  assign present  = (b_st != LS_I) && (b_tag == in_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    chg_en = 1'b0;
    chg_st = LS_I;
    if (is_inv && present) begin
      chg_en = 1'b1;
      chg_st = LS_I;
    end else if (is_fetch && present && (b_st == LS_M)) begin
      chg_en = 1'b1;
      chg_st = LS_S;
    end
    rv_d   = busy;
    rt_d   = is_fetch ? RS_DATA : RS_INVACK;
    rdat_d = present ? b_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rv_d;
  end

  always_ff @(posedge clk) begin
    if (busy) begin
      rsp_type <= rt_d;
      rsp_addr <= in_addr;
      rsp_data <= rdat_d;
    end
  end

  // R5/R6/R10: every invalidate is acknowledged one cycle later
  p_inv_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_inv |=> rsp_valid && (rsp_type == RS_INVACK) && (rsp_addr == $past(in_addr)));
  // R7: a fetch of a dirty line returns its data
  p_fetch_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fetch && present && (b_st == LS_M)) |=> rsp_valid && rsp_type && (rsp_data == $past(b_data)));
endmodule

// File: rtl/coh_miss_ctrl.sv
module coh_miss_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 2,
  parameter int NACK_WAIT = 4,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int CNT_W = $clog2(NACK_WAIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              hit,
  input  logic              probe_busy,
  input  logic [TAG_W-1:0]  v_tag,
  input  line_st_e          v_st,
  input  logic [DATA_W-1:0] v_data,
  input  logic              in_valid,
  input  logic [2:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              idle,
  output logic [ADDR_W-1:0] pend_addr,
  output logic              req_valid,
  output logic [1:0]        req_type,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              fill_en,
  output line_st_e          fill_st,
  output logic              evict_en
);
  typedef enum logic [2:0] {F_IDLE, F_EVICT, F_SEND, F_WAIT, F_HOLD} fsm_e;

  fsm_e              st_q, st_d;
  logic              excl_q, excl_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              match, start;

  assign match = in_valid && (in_addr == pa_q);
  assign start = cpu_valid && !hit && !probe_busy;

  always_comb begin
    st_d   = st_q;
    excl_d = excl_q;
    pa_d   = pa_q;
    cnt_d  = cnt_q;
    unique case (st_q)
      F_IDLE: if (start) begin
        pa_d   = cpu_addr;
        excl_d = cpu_we;
        st_d   = ((v_st == LS_M) && (v_tag != cpu_addr[ADDR_W-1:IDX_W])) ? F_EVICT : F_SEND;
      end
      F_EVICT: st_d = F_SEND;
      F_SEND:  st_d = F_WAIT;
      F_WAIT: begin
        if (match && (in_type == (excl_q ? IM_EXREP : IM_RDREP))) st_d = F_IDLE;
        else if (match && (in_type == IM_NACK)) begin
          st_d  = F_HOLD;
          cnt_d = CNT_W'(NACK_WAIT - 1);
        end
      end
      F_HOLD: begin
        if (cnt_q == '0) st_d = F_SEND;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      excl_q <= 1'b0;
      pa_q   <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      excl_q <= excl_d;
      pa_q   <= pa_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    idle      = (st_q == F_IDLE);
    pend_addr = pa_q;
    req_valid = (st_q == F_EVICT) || (st_q == F_SEND);
    req_type  = (st_q == F_EVICT) ? OQ_WB : (excl_q ? OQ_RDX : OQ_RD);
    req_addr  = (st_q == F_EVICT) ? {v_tag, pa_q[IDX_W-1:0]} : pa_q;
    req_data  = (st_q == F_EVICT) ? v_data : '0;
    evict_en  = (st_q == F_EVICT);
    fill_en   = (st_q == F_WAIT) && match && (in_type == (excl_q ? IM_EXREP : IM_RDREP));
    fill_st   = excl_q ? LS_M : LS_S;
  end

  // R8: a writeback is followed at once by the read for the same set
  p_wb_then_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_type == OQ_WB)) |=>
      req_valid && (req_type != OQ_WB) && (req_addr[IDX_W-1:0] == $past(req_addr[IDX_W-1:0])));
  // R11: a read request is never repeated back to back
  p_single_send_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_type != OQ_WB)) |=> !req_valid);
  // R9: the end of the back-off re-issues the pending address
  p_resend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == F_HOLD) && (cnt_q == '0)) |=> req_valid && (req_addr == $past(pa_q)));
endmodule

// File: rtl/coh_node_agent.sv
module coh_node_agent
  import coh_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int LINES     = 4,
  parameter int NACK_WAIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              req_valid,
  output logic [1:0]        req_type,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              in_valid,
  input  logic [2:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              rsp_valid,
  output logic              rsp_type,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic [IDX_W-1:0]  a_idx, b_idx;
  logic [TAG_W-1:0]  a_tag, b_tag;
  line_st_e          a_st, b_st, fill_st, chg_st;
  logic [DATA_W-1:0] a_data, b_data;
  logic              idle, hit, probe_busy, wr_en, fill_en, evict_en, chg_en;
  logic [ADDR_W-1:0] pend_addr;

  assign a_idx     = idle ? cpu_addr[IDX_W-1:0] : pend_addr[IDX_W-1:0];
  assign hit       = (a_st != LS_I) && (a_tag == cpu_addr[ADDR_W-1:IDX_W]) &&
                     (!cpu_we || (a_st == LS_M));
  assign cpu_ready = idle && cpu_valid && hit && !probe_busy;
  assign cpu_rdata = a_data;
  assign wr_en     = cpu_ready && cpu_we;

  coh_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_sn),
    .a_idx(a_idx), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
    .b_idx(b_idx), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
    .fill_en(fill_en), .fill_idx(pend_addr[IDX_W-1:0]),
    .fill_tag(pend_addr[ADDR_W-1:IDX_W]), .fill_data(in_data), .fill_st(fill_st),
    .wr_en(wr_en), .wr_idx(cpu_addr[IDX_W-1:0]), .wr_data(cpu_wdata),
    .inv_en(evict_en), .inv_idx(pend_addr[IDX_W-1:0]),
    .chg_en(chg_en), .chg_idx(b_idx), .chg_st(chg_st)
  );

  coh_probe_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_probe (
    .clk(clk), .rst_n(rst_sn),
    .in_valid(in_valid), .in_type(in_type), .in_addr(in_addr),
    .b_idx(b_idx), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
    .busy(probe_busy), .chg_en(chg_en), .chg_st(chg_st),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  coh_miss_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
                  .NACK_WAIT(NACK_WAIT)) u_miss (
    .clk(clk), .rst_n(rst_sn),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .hit(hit), .probe_busy(probe_busy),
    .v_tag(a_tag), .v_st(a_st), .v_data(a_data),
    .in_valid(in_valid), .in_type(in_type), .in_addr(in_addr),
    .idle(idle), .pend_addr(pend_addr),
    .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr), .req_data(req_data),
    .fill_en(fill_en), .fill_st(fill_st), .evict_en(evict_en)
  );

  // R11: the processor is stalled while a miss is outstanding
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    !idle |-> !cpu_ready);
  // R12: nothing is driven out of reset
  p_quiet_reset_r12: assert property (@(posedge clk)
    !rst_sn |-> !req_valid && !cpu_ready);
endmodule

// File: tb/test_coh_node_agent.sv
module test_coh_node_agent;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_valid, cpu_we;
  logic [7:0]  cpu_addr;
  logic [31:0] cpu_wdata;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        req_valid;
  logic [1:0]  req_type;
  logic [7:0]  req_addr;
  logic [31:0] req_data;
  logic        in_valid;
  logic [2:0]  in_type;
  logic [7:0]  in_addr;
  logic [31:0] in_data;
  logic        rsp_valid, rsp_type;
  logic [7:0]  rsp_addr;
  logic [31:0] rsp_data;

  always #5 clk = ~clk;

  coh_node_agent i_coh_node_agent (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr), .req_data(req_data),
    .in_valid(in_valid), .in_type(in_type), .in_addr(in_addr), .in_data(in_data),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // bench model: line state 0 invalid, 1 shared, 2 modified
  logic [5:0]  mtag  [4];
  logic [1:0]  mst   [4];
  logic [31:0] mdata [4];
  logic [31:0] mem   [256];

  function automatic logic [31:0] memv(input int a);
    return 32'hA500_0000 ^ (a * 32'h0001_0203);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cpu_access(input bit we, input logic [7:0] a, input logic [31:0] wd,
                            input int nacks, input bit inj);
    logic [1:0] idx = a[1:0];
    logic [5:0] tg = a[7:2];
    bit hit = (mst[idx] != 0) && (mtag[idx] == tg) && (!we || mst[idx] == 2);
    bit evict = !hit && (mst[idx] == 2) && (mtag[idx] != tg);
    int exp_lat = hit ? 0 : 3 + int'(evict) + 6 * nacks + int'(inj);
    string rq = hit ? (we ? "R4" : "R1") : (we ? "R3" : "R2");
    int reply_in = 0, msg_n = 0, nack_cyc = -100, ready_cyc = -1, nl = nacks;
    bit rsp_seen = 0, done = 0;
    logic [31:0] rd = '0;
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    for (int cyc = 0; cyc < 60; cyc++) begin
      if (reply_in == 2 && inj) begin
        in_valid = 1; in_type = 3'd2; in_addr = a; in_data = '0;
      end else if (reply_in == 1) begin
        in_valid = 1; in_addr = a; in_data = mem[a];
        if (nl > 0) begin in_type = 3'd4; nl--; nack_cyc = cyc; end
        else in_type = we ? 3'd1 : 3'd0;
      end
      if (reply_in > 0) reply_in--;
      #1;
      if (rsp_valid) rsp_seen = 1;
      if (req_valid) begin
        if (evict && msg_n == 0) begin
          chk("R8 wb type", 32'(req_type), 32'd2);
          chk("R8 wb addr", 32'(req_addr), 32'({mtag[idx], idx}));
          chk("R8 wb data", req_data, mdata[idx]);
          mem[{mtag[idx], idx}] = mdata[idx];
        end else begin
          chk({rq, " req type"}, 32'(req_type), we ? 32'd1 : 32'd0);
          chk({rq, " req addr"}, 32'(req_addr), 32'(a));
          if (nack_cyc >= 0) chk("R9 resend cycle", 32'(cyc), 32'(nack_cyc + 5));
          reply_in = inj ? 2 : 1;
        end
        msg_n++;
      end
      if (cpu_ready) begin
        done = 1; ready_cyc = cyc; rd = cpu_rdata;
      end
      @(posedge clk);
      #1;
      in_valid = 0;
      if (done) break;
    end
    cpu_valid = 0;
    chk({rq, " completion cycle (R11 stall)"}, 32'(ready_cyc), 32'(exp_lat));
    chk({rq, " message count"}, 32'(msg_n), hit ? 32'd0 : 32'(int'(evict) + 1 + nacks));
    if (inj) chk("R10 ack during miss", 32'(rsp_seen), 32'd1);
    if (!hit) begin
      mtag[idx] = tg; mdata[idx] = mem[a]; mst[idx] = we ? 2'd2 : 2'd1;
    end
    if (we) begin mdata[idx] = wd; mst[idx] = 2'd2; end
    else chk({rq, " load data"}, rd, mdata[idx]);
  endtask

  task automatic probe(input bit fetch, input logic [7:0] a);
    logic [1:0] idx = a[1:0];
    bit present = (mst[idx] != 0) && (mtag[idx] == a[7:2]);
    string r = fetch ? "R7" : (present ? "R5" : "R6");
    in_valid = 1; in_type = fetch ? 3'd3 : 3'd2; in_addr = a; in_data = '0;
    tick();
    in_valid = 0;
    #1;
    chk({r, " rsp valid"}, 32'(rsp_valid), 32'd1);
    chk({r, " rsp type"}, 32'(rsp_type), 32'(fetch));
    chk({r, " rsp addr"}, 32'(rsp_addr), 32'(a));
    if (fetch) chk({r, " rsp data"}, rsp_data, present ? mdata[idx] : 32'd0);
    if (present) begin
      if (!fetch) mst[idx] = 0;
      else if (mst[idx] == 2) begin mem[a] = mdata[idx]; mst[idx] = 1; end
    end
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) begin mst[i] = 0; mtag[i] = 0; mdata[i] = 0; end
    for (int i = 0; i < 256; i++) mem[i] = memv(i);
    rst_n = 0; cpu_valid = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    in_valid = 0; in_type = 0; in_addr = 0; in_data = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    // R12: quiet after reset
    chk("R12 req_valid", 32'(req_valid), 32'd0);
    chk("R12 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R12 cpu_ready", 32'(cpu_ready), 32'd0);
    cpu_access(0, 8'h05, 0, 0, 0);             // R2 miss (R12: lines start invalid)
    cpu_access(0, 8'h05, 0, 0, 0);             // R1 hit
    cpu_access(1, 8'h05, 32'h1111_2222, 0, 0); // R3 upgrade from shared
    cpu_access(1, 8'h05, 32'h3333_4444, 0, 0); // R4 hit on modified
    cpu_access(0, 8'h0D, 0, 0, 0);             // R8 dirty victim
    cpu_access(1, 8'h0D, 32'h5555_6666, 0, 1); // R10 invalidate during upgrade
    probe(1, 8'h0D);                           // R7 fetch of modified line
    cpu_access(1, 8'h0D, 32'h7777_8888, 0, 0); // R7 downgraded: needs ownership again
    probe(0, 8'h11);                           // R6 absent invalidate
    cpu_access(0, 8'h0D, 0, 0, 0);             // R6 resident line still hits
    probe(0, 8'h0D);                           // R5 present invalidate
    cpu_access(0, 8'h0D, 0, 0, 0);             // R5 line now misses
    probe(1, 8'h21);                           // R7 fetch of absent line
    cpu_access(0, 8'h02, 0, 1, 0);             // R9 one back-off
    cpu_access(1, 8'h03, 32'hABCD_0123, 2, 0); // R9 two back-offs
    for (int n = 0; n < 400; n++) begin
      int op = $urandom % 8;
      logic [7:0] a = 8'($urandom % 32);
      if (op < 3) cpu_access(0, a, 0, ($urandom % 8 == 0) ? 1 : 0, 0);
      else if (op < 6) cpu_access(1, a, $urandom, ($urandom % 8 == 0) ? 1 : 0, 0);
      else probe(op == 7, a);
    end
    done_flag = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule